// File: doc/BRIEF.md
# Configurable Registered Command Buffer

This block is a clocked register placed between a memory controller and the address and command lines of a memory module. Two static configuration inputs select its mode. In the wide mode it registers 25 lanes one to one. In the split mode it registers 14 lanes and drives each registered value onto an A copy and a B copy. The split mode has two lane maps, and they differ in which lanes carry the clock-enable and on-die-termination signals.

A pair of chip-select inputs can freeze the data lanes. When both are high at a rising clock edge, the ordinary data lanes keep their values. The clock-enable and on-die-termination lanes of the active split map still load every edge, and so does the registered chip-select output. An active-low asynchronous reset clears every register, forces all outputs low, and overrides the freeze. Configuration is expected to change only while reset is held.

Top module: `cfg_reg_cmd_buffer`

## Requirements
- R1: With cfg_split low, each rising edge loads din[24:0] into q_a[24:0], and q_b stays all zero.
- R2: With cfg_split high, each rising edge loads din[13:0] into both q_a[13:0] and q_b[13:0]. q_a[24:14] stays zero, and din[24:14] has no effect.
- R3: Outputs change only at a rising clock edge. A new input value shows up after the next edge and not before.
- R4: While rst_n is low, q_a, q_b and q_cs are zero. This takes effect at once, without any clock edge.
- R5: If cs_dev and cs_rank are both high at an edge, every gated lane keeps its value. In the wide mode all 25 lanes are gated.
- R6: If either chip select is low at an edge, all live lanes load din.
- R7: q_cs loads cs_dev on every edge, whatever the freeze state.
- R8: In split mode with cfg_alt low (map A), lanes 0 (clock enable) and 3 (termination) load din even while the lanes are frozen.
- R9: In split mode with cfg_alt high (map B), lanes 13 (clock enable) and 10 (termination) load din even while the lanes are frozen.
- R10: Reset wins over the freeze. Asserting rst_n low while both chip selects are high still clears all outputs.
- R11: With cs_rank held low, no freeze ever happens, and cs_dev acts as a plain registered input on q_cs.
- R12: After reset is released with din and the chip selects low, every output stays zero on every following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge capture clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_split | input | 1 | 0: 25-lane 1:1, 1: 14-lane 1:2 |
| cfg_alt | input | 1 | Split map select, 0: map A, 1: map B |
| cs_dev | input | 1 | Device chip select, registered to q_cs |
| cs_rank | input | 1 | Second chip select; freeze when both high |
| din | input | 25 | Lane inputs |
| q_a | output | 25 | Registered lanes, A copy |
| q_b | output | 14 | Registered lanes, B copy (split mode) |
| q_cs | output | 1 | Registered cs_dev |

## Verification
The freeze and the asynchronous reset can land in the same cycle. The bench holds both chip selects high with frozen nonzero lanes, then pulls rst_n low halfway between clock edges. It judges the result by checking that all outputs read zero before the next edge arrives. A second overlap occurs within one edge: frozen lanes hold while the ungated clock-enable and termination lanes of the same register load new data. The bench provokes this with all-ones and all-zeros patterns and compares every lane.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;
    localparam int LANES_WIDE  = 25;
    localparam int LANES_SPLIT = 14;
    localparam int CKE_MAP_A   = 0;
    localparam int ODT_MAP_A   = 3;
    localparam int CKE_MAP_B   = 13;
    localparam int ODT_MAP_B   = 10;

    typedef enum logic [1:0] {
        MODE_WIDE    = 2'd0,
        MODE_SPLIT_A = 2'd1,
        MODE_SPLIT_B = 2'd2
    } buf_mode_e;
endpackage

// File: rtl/cmdbuf_mode_decode.sv
module cmdbuf_mode_decode
    import cmdbuf_pkg::*;
#(
    parameter int WIDE  = LANES_WIDE,
    parameter int SPLIT = LANES_SPLIT,
    parameter int CKE_A = CKE_MAP_A,
    parameter int ODT_A = ODT_MAP_A,
    parameter int CKE_B = CKE_MAP_B,
    parameter int ODT_B = ODT_MAP_B
) (
    input  logic            cfg_split,
    input  logic            cfg_alt,
    output logic [WIDE-1:0] live_mask,
    output logic [WIDE-1:0] free_mask
);
    buf_mode_e mode;

    always_comb begin
        if (!cfg_split)   mode = MODE_WIDE;
        else if (cfg_alt) mode = MODE_SPLIT_B;
        else              mode = MODE_SPLIT_A;
    end

    for (genvar i = 0; i < WIDE; i++) begin : g_lane
        localparam bit IN_SPLIT = (i < SPLIT);
        localparam bit IS_A     = (i == CKE_A) || (i == ODT_A);
        localparam bit IS_B     = (i == CKE_B) || (i == ODT_B);
        always_comb begin
            unique case (mode)
                MODE_SPLIT_A: begin
                    live_mask[i] = IN_SPLIT;
                    free_mask[i] = IS_A;
                end
                MODE_SPLIT_B: begin
                    live_mask[i] = IN_SPLIT;
                    free_mask[i] = IS_B;
                end
                default: begin
                    live_mask[i] = 1'b1;
                    free_mask[i] = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/cmdbuf_lane_next.sv
module cmdbuf_lane_next #(
    parameter int WIDE = 25
) (
    input  logic            freeze,
    input  logic [WIDE-1:0] live_mask,
    input  logic [WIDE-1:0] free_mask,
    input  logic [WIDE-1:0] din,
    input  logic [WIDE-1:0] lane_q,
    output logic [WIDE-1:0] lane_d
);
    for (genvar i = 0; i < WIDE; i++) begin : g_next
        always_comb begin
            if (!live_mask[i])
                lane_d[i] = 1'b0;
            else if (freeze && !free_mask[i])
                lane_d[i] = lane_q[i];
            else
                lane_d[i] = din[i];
        end
    end
endmodule

// File: rtl/cmdbuf_fanout.sv
module cmdbuf_fanout #(
    parameter int SPLIT = 14
) (
    input  logic             cfg_split,
    input  logic [SPLIT-1:0] lane_q,
    output logic [SPLIT-1:0] copy_b
);
    for (genvar i = 0; i < SPLIT; i++) begin : g_copy
        assign copy_b[i] = cfg_split & lane_q[i];
    end
endmodule

// File: rtl/cfg_reg_cmd_buffer.sv
module cfg_reg_cmd_buffer
    import cmdbuf_pkg::*;
#(
    parameter int WIDE  = LANES_WIDE,
    parameter int SPLIT = LANES_SPLIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_split,
    input  logic             cfg_alt,
    input  logic             cs_dev,
    input  logic             cs_rank,
    input  logic [WIDE-1:0]  din,
    output logic [WIDE-1:0]  q_a,
    output logic [SPLIT-1:0] q_b,
    output logic             q_cs
);
    typedef struct packed {
        logic [WIDE-1:0] lanes;
        logic            cs;
    } state_t;

    state_t          st_d, st_q;
    logic            freeze;
    logic [WIDE-1:0] live_mask, free_mask, lane_nxt;

    assign freeze = cs_dev & cs_rank;

    cmdbuf_mode_decode #(.WIDE(WIDE), .SPLIT(SPLIT)) u_decode (
        .cfg_split (cfg_split),
        .cfg_alt   (cfg_alt),
        .live_mask (live_mask),
        .free_mask (free_mask)
    );

    cmdbuf_lane_next #(.WIDE(WIDE)) u_next (
        .freeze    (freeze),
        .live_mask (live_mask),
        .free_mask (free_mask),
        .din       (din),
        .lane_q    (st_q.lanes),
        .lane_d    (lane_nxt)
    );

    always_comb begin
        st_d       = st_q;
        st_d.lanes = lane_nxt;
        st_d.cs    = cs_dev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    cmdbuf_fanout #(.SPLIT(SPLIT)) u_fanout (
        .cfg_split (cfg_split),
        .lane_q    (st_q.lanes[SPLIT-1:0]),
        .copy_b    (q_b)
    );

    assign q_a  = st_q.lanes;
    assign q_cs = st_q.cs;

    assert_reset_low_R4: assert property (@(posedge clk)
        !rst_n |-> (q_a == '0 && q_b == '0 && !q_cs));

    assert_wide_b_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_split |-> q_b == '0);

    assert_split_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_split |-> (q_b == q_a[SPLIT-1:0] && q_a[WIDE-1:SPLIT] == '0));

    assert_frozen_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_dev && cs_rank) |=> ((q_a & ~free_mask) == $past(q_a & ~free_mask)));

    assert_open_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs_dev && cs_rank) |=> q_a == $past(din & live_mask));

    assert_cs_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> q_cs == $past(cs_dev));
endmodule

// File: tb/cfg_reg_cmd_buffer_test.sv
`timescale 1ns/100ps
module cfg_reg_cmd_buffer_test;
    localparam int WIDE  = 25;
    localparam int SPLIT = 14;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_split = 1'b0, cfg_alt = 1'b0;
    logic             cs_dev = 1'b0, cs_rank = 1'b0;
    logic [WIDE-1:0]  din = '0;
    logic [WIDE-1:0]  q_a;
    logic [SPLIT-1:0] q_b;
    logic             q_cs;
    int               n_checks = 0, n_fails = 0;

    always #2 clk = ~clk;

    cfg_reg_cmd_buffer #(.WIDE(WIDE), .SPLIT(SPLIT)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_split(cfg_split), .cfg_alt(cfg_alt),
        .cs_dev(cs_dev), .cs_rank(cs_rank), .din(din),
        .q_a(q_a), .q_b(q_b), .q_cs(q_cs)
    );

    typedef struct packed {
        logic             cdev;
        logic             crank;
        logic [WIDE-1:0]  vin;
        logic [SPLIT-1:0] exp;
        logic             ecs;
    } vec_t;

    // split map A run; free lanes are 0 and 3
    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b0, 25'h1FFD234, 14'h1234, 1'b0},
        '{1'b1, 1'b1, 25'h1FFFFFF, 14'h123D, 1'b1},
        '{1'b1, 1'b1, 25'h1FFC000, 14'h1234, 1'b1},
        '{1'b1, 1'b0, 25'h0002AAA, 14'h2AAA, 1'b1},
        '{1'b0, 1'b1, 25'h1FFD555, 14'h1555, 1'b0},
        '{1'b1, 1'b1, 25'h0000000, 14'h1554, 1'b1}
    };

    task automatic check(input string rq, input logic [WIDE-1:0] got,
                         input logic [WIDE-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", rq, got, exp);
        end
    endtask

    task automatic outs(input string rq, input logic [WIDE-1:0] ea,
                        input logic [SPLIT-1:0] eb, input logic ecs);
        check(rq, q_a, ea);
        check(rq, {{(WIDE-SPLIT){1'b0}}, q_b}, {{(WIDE-SPLIT){1'b0}}, eb});
        check(rq, {{(WIDE-1){1'b0}}, q_cs}, {{(WIDE-1){1'b0}}, ecs});
    endtask

    task automatic do_reset(input logic split, input logic alt);
        @(negedge clk);
        rst_n = 1'b0; cfg_split = split; cfg_alt = alt;
        din = '0; cs_dev = 1'b0; cs_rank = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input logic cd, input logic cr, input logic [WIDE-1:0] v);
        @(negedge clk);
        cs_dev = cd; cs_rank = cr; din = v;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 4);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #1;
        outs("R4 reset state", '0, '0, 1'b0);

        // table: split mode, map A (R2, R5, R6, R7, R8)
        do_reset(1'b1, 1'b0);
        foreach (VECS[i]) begin
            step(VECS[i].cdev, VECS[i].crank, VECS[i].vin);
            outs($sformatf("R2/R5/R6/R7/R8 vector %0d", i),
                 {{(WIDE-SPLIT){1'b0}}, VECS[i].exp}, VECS[i].exp, VECS[i].ecs);
        end

        // wide mode R1, R5
        do_reset(1'b0, 1'b0);
        step(1'b0, 1'b0, 25'h1ABCDEF);
        outs("R1 wide load", 25'h1ABCDEF, '0, 1'b0);
        step(1'b1, 1'b1, 25'h0555555);
        outs("R5 wide frozen", 25'h1ABCDEF, '0, 1'b1);

        // R3: no change before the edge
        @(negedge clk);
        cs_dev = 1'b0; cs_rank = 1'b0; din = 25'h0F0F0F0;
        #1;
        check("R3 before edge", q_a, 25'h1ABCDEF);
        @(posedge clk); #1;
        check("R3 after edge", q_a, 25'h0F0F0F0);

        // R10 + R4: reset during freeze, between edges
        step(1'b1, 1'b1, 25'h1FFFFFF);
        outs("R5 frozen before reset", 25'h0F0F0F0, '0, 1'b1);
        @(posedge clk); #0.5;
        rst_n = 1'b0;
        #0.5;
        outs("R10 reset beats freeze", '0, '0, 1'b0);

        // map B R9
        do_reset(1'b1, 1'b1);
        step(1'b0, 1'b0, 25'h0003FFF);
        outs("R9 map B load", 25'h0003FFF, 14'h3FFF, 1'b0);
        step(1'b1, 1'b1, 25'h0000000);
        outs("R9 map B free lanes", 25'h0001BFF, 14'h1BFF, 1'b1);

        // R11: cs_rank low, cs_dev as data
        step(1'b1, 1'b0, 25'h0000AAA);
        outs("R11 dev high no freeze", 25'h0000AAA, 14'h0AAA, 1'b1);
        step(1'b0, 1'b0, 25'h0000555);
        outs("R11 dev low", 25'h0000555, 14'h0555, 1'b0);

        // R12: quiet release
        do_reset(1'b1, 1'b1);
        for (int k = 0; k < 4; k++) begin
            step(1'b0, 1'b0, '0);
            outs("R12 quiet after reset", '0, '0, 1'b0);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule